// File: doc/BRIEF.md
# Interprocessor Mailbox Message Unit

A register-mapped peripheral through which processors pass 32-bit words to one another. It contains six separate mailboxes. Each mailbox is a four-entry hardware FIFO. A sender writes a word to the message register of a mailbox, which pushes the word. A receiver reads the same register, which pops the oldest word. Per-mailbox status registers report whether the FIFO is full and how many words it holds.

Four interrupt users share the mailboxes. Every user has its own event-status register, its own event-enable register and its own interrupt line. Each mailbox owns a two-bit field in every user's registers: one bit for "new message" and one for "not full". A processor therefore subscribes only to the mailbox events it handles. It acknowledges them by writing ones to its status register. A small configuration register holds idle-control bits for the surrounding system.

Bus accesses are single-cycle. Read data is combinational from the address. A pop or a push takes effect on the clock edge that ends the access.

Top module: `mbox_hub`

## Requirements
- R1: After reset, all mailboxes are empty and every event-status and event-enable register reads 0. The configuration register reads 0 and all interrupt lines are low. Offset 0x00 reads the revision constant 0x00000020. Offset 0x14 reads 1 once the first clock after reset has passed.
- R2: Byte offsets are decoded with bits [1:0] required to be zero, and the map is fixed:
  - The message register of mailbox m is at 0x40+4m.
  - The full-flag register of mailbox m is at 0x80+4m.
  - The word-count register of mailbox m is at 0xC0+4m.
  - The event status of user u is at 0x100+8u, and its event enable is at 0x104+8u.
  - Any other or misaligned offset reads 0, and a write to it changes nothing.
- R3: A write to a message register pushes the write data. A read returns the oldest queued word in the same cycle and removes it at the clock edge. The six mailboxes keep separate queues.
- R4: Each mailbox holds 4 words. Its word-count register reads the count (0 to 4) in bits [2:0]. Its full-flag register reads 1 when the count is 4 and 0 otherwise.
- R5: A write to the message register of a full mailbox is dropped. The count and the queued words are unchanged.
- R6: A read of the message register of an empty mailbox returns 0. It changes no queue and raises no event.
- R7: Every accepted push into mailbox m sets bit 2m in the event status of all four users. Every accepted pop from mailbox m sets bit 2m+1 in all four users.
- R8: Writing to an event-status register clears each bit written as 1 and leaves each bit written as 0. An event in the same cycle takes precedence over the clear.
- R9: Event-enable registers are read/write in bits [11:0]. Interrupt line u is high exactly when some bit is set in both the event status and the event enable of user u.
- R10: The configuration register stores bit 0 (automatic idle) and bits [4:3] (idle mode, where smart idle sets bit 4). Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 9 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| irq_out | output | 4 | One interrupt line per user |

## Verification
The bench targets the following corner cases:
- **Fill and overflow.** The bench fills a mailbox to its fourth word and pushes one more. A design that wraps its pointer or lets its count grow would return the dropped word or a corrupted order.
- **Pop from empty.** A design without the empty guard would return stale storage or move its read pointer, and would wrongly raise a not-full event.
- **Status and interrupt routing.** Write-one-clear is checked against write-zero. Events are checked to land in all four users. The bench watches the interrupt lines every cycle, so a crossed bit position, a missed user, or an interrupt that ignores its enable mask all show up.
- **Decode edges.** Misaligned offsets, the offset just above the last mailbox, and the unmapped top of the space are exercised. This catches decoders that ignore the low address bits or alias beyond six mailboxes.

// File: rtl/mbox_pkg.sv
// Package: shared constants for the mailbox unit.
// Word offsets (byte offset / 4) of each register region and the
// writable mask of the configuration register.
package mbox_pkg;

    localparam int W_REV  = 0;   // revision constant
    localparam int W_CFG  = 4;   // configuration register
    localparam int W_SYS  = 5;   // reset-done status
    localparam int W_MSG  = 16;  // first message register
    localparam int W_FST  = 32;  // first full-flag register
    localparam int W_MST  = 48;  // first word-count register
    localparam int W_IRQ  = 64;  // first event-status register

    localparam logic [31:0] CFG_MASK = 32'h0000_0019;

endpackage

// File: rtl/mbox_decode.sv
// Module: mbox_decode
// Turns a byte offset into one-hot hit lines for each register.
// Assumes: offsets with bits [1:0] non-zero select nothing; mailbox
// count is at most 16 and user count at most 16 so regions stay apart.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int N_BOX  = 6,
    parameter int N_USER = 4,
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [N_BOX-1:0]  msg_hit,
    output logic [N_BOX-1:0]  fst_hit,
    output logic [N_BOX-1:0]  mst_hit,
    output logic [N_USER-1:0] ist_hit,
    output logic [N_USER-1:0] ien_hit,
    output logic              rev_hit,
    output logic              cfg_hit,
    output logic              sys_hit
);

    localparam int WW = ADDR_W - 2;

    logic          aligned;
    logic [WW-1:0] word;
    int            word_i;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];
    assign word_i  = int'(word);

    // fixed single registers
    assign rev_hit = aligned && (word_i == W_REV);
    assign cfg_hit = aligned && (word_i == W_CFG);
    assign sys_hit = aligned && (word_i == W_SYS);

    // per-mailbox registers
    for (genvar m = 0; m < N_BOX; m++) begin : g_box
        assign msg_hit[m] = aligned && (word_i == W_MSG + m);
        assign fst_hit[m] = aligned && (word_i == W_FST + m);
        assign mst_hit[m] = aligned && (word_i == W_MST + m);
    end

    // per-user status / enable pairs
    for (genvar u = 0; u < N_USER; u++) begin : g_user
        assign ist_hit[u] = aligned && (word_i == W_IRQ + 2*u);
        assign ien_hit[u] = aligned && (word_i == W_IRQ + 2*u + 1);
    end

endmodule

// File: rtl/mbox_fifo.sv
// Module: mbox_fifo
// One mailbox queue: a circular buffer with a word count.
// Pushes when full and pops when empty are refused and reported
// through push_ok / pop_ok. Head reads zero while empty.
// Assumes: DEPTH >= 2.
module mbox_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              push,
    input  logic                              pop,
    input  logic [DATA_W-1:0]                 wdata,
    output logic [DATA_W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]        count,
    output logic                              full,
    output logic                              push_ok,
    output logic                              pop_ok
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [CNT_W-1:0]  cnt_q;
    logic              empty;

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];
    assign count   = cnt_q;

    // storage write on accepted push
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= wdata;
        end
    end

    // write pointer advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (push_ok) begin
            wr_ptr <= (wr_ptr == PTR_W'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
        end
    end

    // read pointer advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop_ok) begin
            rd_ptr <= (rd_ptr == PTR_W'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
        end
    end

    // occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/mbox_irq_user.sv
// Module: mbox_irq_user
// Event status and enable for one interrupt user, plus its line.
// Status bits are set by event pulses and cleared by write-one.
// A set and a clear in the same cycle leave the bit set.
module mbox_irq_user #(
    parameter int EV_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] set_ev,
    input  logic            st_we,
    input  logic            en_we,
    input  logic [EV_W-1:0] wdata,
    output logic [EV_W-1:0] status,
    output logic [EV_W-1:0] enable,
    output logic            irq
);

    logic [EV_W-1:0] clr_mask;

    assign clr_mask = st_we ? wdata : '0;
    assign irq      = |(status & enable);

    // sticky status: clear by write-one, set by event (set wins)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status <= '0;
        end else begin
            status <= (status & ~clr_mask) | set_ev;
        end
    end

    // plain read/write enable mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
        end else if (en_we) begin
            enable <= wdata;
        end
    end

endmodule

// File: rtl/mbox_hub.sv
// Module: mbox_hub (top)
// Mailbox unit: N_BOX message FIFOs and N_USER interrupt users
// behind a single-cycle register bus. Reads are combinational; a
// read of a message register pops at the clock edge ending the access.
// Assumes: the bus never asserts bus_rd and bus_wr in the same cycle;
// DATA_W >= 2*N_BOX and DATA_W >= 5.
module mbox_hub
    import mbox_pkg::*;
#(
    parameter int          N_BOX  = 6,
    parameter int          N_USER = 4,
    parameter int          DEPTH  = 4,
    parameter int          DATA_W = 32,
    parameter int          ADDR_W = 9,
    parameter logic [31:0] REV_ID = 32'h0000_0020
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_USER-1:0] irq_out
);

    localparam int EV_W  = 2 * N_BOX;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [N_BOX-1:0]             msg_hit;
    logic [N_BOX-1:0]             fst_hit;
    logic [N_BOX-1:0]             mst_hit;
    logic [N_USER-1:0]            ist_hit;
    logic [N_USER-1:0]            ien_hit;
    logic                         rev_hit;
    logic                         cfg_hit;
    logic                         sys_hit;

    logic [N_BOX-1:0][DATA_W-1:0] head_all;
    logic [N_BOX-1:0][CNT_W-1:0]  cnt_all;
    logic [N_BOX-1:0]             full_v;
    logic [N_BOX-1:0]             push_ok;
    logic [N_BOX-1:0]             pop_ok;
    logic [EV_W-1:0]              events;

    logic [N_USER-1:0][EV_W-1:0]  st_all;
    logic [N_USER-1:0][EV_W-1:0]  en_all;

    logic [DATA_W-1:0]            cfg_q;
    logic                         done_q;

    mbox_decode #(
        .N_BOX  (N_BOX),
        .N_USER (N_USER),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr    (bus_addr),
        .msg_hit (msg_hit),
        .fst_hit (fst_hit),
        .mst_hit (mst_hit),
        .ist_hit (ist_hit),
        .ien_hit (ien_hit),
        .rev_hit (rev_hit),
        .cfg_hit (cfg_hit),
        .sys_hit (sys_hit)
    );

    // one FIFO per mailbox; its accept pulses become events
    for (genvar m = 0; m < N_BOX; m++) begin : g_box
        mbox_fifo #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH)
        ) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (bus_wr && msg_hit[m]),
            .pop     (bus_rd && msg_hit[m]),
            .wdata   (bus_wdata),
            .head    (head_all[m]),
            .count   (cnt_all[m]),
            .full    (full_v[m]),
            .push_ok (push_ok[m]),
            .pop_ok  (pop_ok[m])
        );
        assign events[2*m]   = push_ok[m];
        assign events[2*m+1] = pop_ok[m];
    end

    // one status/enable pair and line per interrupt user
    for (genvar u = 0; u < N_USER; u++) begin : g_user
        mbox_irq_user #(
            .EV_W (EV_W)
        ) u_irq (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (events),
            .st_we  (bus_wr && ist_hit[u]),
            .en_we  (bus_wr && ien_hit[u]),
            .wdata  (bus_wdata[EV_W-1:0]),
            .status (st_all[u]),
            .enable (en_all[u]),
            .irq    (irq_out[u])
        );
    end

    // configuration register, writable bits only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (bus_wr && cfg_hit) begin
            cfg_q <= bus_wdata & DATA_W'(CFG_MASK);
        end
    end

    // reset-done flag, set on the first clock after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b1;
        end
    end

    // read data multiplexer (OR of one-hot selected sources)
    always_comb begin
        bus_rdata = '0;
        if (rev_hit) bus_rdata = bus_rdata | DATA_W'(REV_ID);
        if (cfg_hit) bus_rdata = bus_rdata | cfg_q;
        if (sys_hit) bus_rdata = bus_rdata | DATA_W'(done_q);
        for (int m = 0; m < N_BOX; m++) begin
            if (msg_hit[m]) bus_rdata = bus_rdata | head_all[m];
            if (fst_hit[m]) bus_rdata = bus_rdata | DATA_W'(full_v[m]);
            if (mst_hit[m]) bus_rdata = bus_rdata | DATA_W'(cnt_all[m]);
        end
        for (int u = 0; u < N_USER; u++) begin
            if (ist_hit[u]) bus_rdata = bus_rdata | DATA_W'(st_all[u]);
            if (ien_hit[u]) bus_rdata = bus_rdata | DATA_W'(en_all[u]);
        end
    end

endmodule

// File: rtl/mbox_hub_chk.sv
// Module: mbox_hub_chk
// Property checker bound into mbox_hub. Observes decode hits, FIFO
// state, event status and the bus/interrupt ports.
module mbox_hub_chk #(
    parameter int N_BOX  = 6,
    parameter int N_USER = 4,
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32
) (
    input logic                                      clk,
    input logic                                      rst_n,
    input logic                                      bus_rd,
    input logic                                      bus_wr,
    input logic [DATA_W-1:0]                         bus_rdata,
    input logic [N_USER-1:0]                         irq_out,
    input logic [N_BOX-1:0]                          msg_hit,
    input logic [N_BOX-1:0]                          full_v,
    input logic [N_BOX-1:0][$clog2(DEPTH+1)-1:0]     cnt_all,
    input logic [N_BOX-1:0]                          push_ok,
    input logic [N_USER-1:0][2*N_BOX-1:0]            st_all,
    input logic [N_USER-1:0][2*N_BOX-1:0]            en_all
);

    localparam int CNT_W = $clog2(DEPTH+1);

    for (genvar m = 0; m < N_BOX; m++) begin : g_box
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_all[m] <= CNT_W'(DEPTH)); // R4

        AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && !bus_rd && msg_hit[m] && full_v[m]) |=> $stable(cnt_all[m])); // R5

        AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_rd && msg_hit[m] && cnt_all[m] == '0) |-> bus_rdata == '0); // R6

        for (genvar u = 0; u < N_USER; u++) begin : g_user
            AST_NEWMSG_SET: assert property (@(posedge clk) disable iff (!rst_n)
                push_ok[m] |=> st_all[u][2*m]); // R7
        end
    end

    for (genvar u = 0; u < N_USER; u++) begin : g_line
        AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
            (en_all[u] == '0) |-> !irq_out[u]); // R9
    end

endmodule

bind mbox_hub mbox_hub_chk #(
    .N_BOX  (N_BOX),
    .N_USER (N_USER),
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .msg_hit   (msg_hit),
    .full_v    (full_v),
    .cnt_all   (cnt_all),
    .push_ok   (push_ok),
    .st_all    (st_all),
    .en_all    (en_all)
);

// File: tb/sim_mbox_hub.sv
// Bench: behavioural reference model (queues + integer registers)
// compared on every bus read and on the interrupt lines each clock.
module sim_mbox_hub;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;
    localparam int NU = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  irq_out;

    int tests = 0;
    int fails = 0;
    bit running = 0;

    // reference state
    logic [31:0] q [NB][$];
    logic [31:0] st [NU];
    logic [31:0] en [NU];
    logic [31:0] cfg = 0;

    mbox_hub u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int a);
        int w;
        if (a % 4 != 0) return 0;
        w = a / 4;
        if (a == 0)    return 32'h20;
        if (a == 'h10) return cfg;
        if (a == 'h14) return 1;
        if (w >= 16 && w < 16 + NB) return (q[w-16].size() > 0) ? q[w-16][0] : 0;
        if (w >= 32 && w < 32 + NB) return (q[w-32].size() == 4) ? 1 : 0;
        if (w >= 48 && w < 48 + NB) return q[w-48].size();
        if (a >= 'h100 && a < 'h120) return (a % 8 == 0) ? st[(a-'h100)/8] : en[(a-'h100)/8];
        return 0;
    endfunction

    task automatic model_apply(input bit rd, input bit wr, input int a, input logic [31:0] d);
        int w;
        if (a % 4 != 0) return;
        w = a / 4;
        if (wr) begin
            if (w >= 16 && w < 16 + NB) begin
                if (q[w-16].size() < 4) begin
                    q[w-16].push_back(d);
                    for (int u = 0; u < NU; u++) st[u] |= 32'(1) << (2*(w-16));
                end
            end else if (a == 'h10) begin
                cfg = d & 32'h19;
            end else if (a >= 'h100 && a < 'h120) begin
                if (a % 8 == 0) st[(a-'h100)/8] &= ~d;
                else            en[(a-'h100)/8] = d & 32'hFFF;
            end
        end
        if (rd && w >= 16 && w < 16 + NB) begin
            if (q[w-16].size() > 0) begin
                void'(q[w-16].pop_front());
                for (int u = 0; u < NU; u++) st[u] |= 32'(1) << (2*(w-16)+1);
            end
        end
    endtask

    task automatic bus_write(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a[8:0]; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        model_apply(1'b0, 1'b1, a, d);
    endtask

    task automatic bus_read(input int a, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a[8:0];
        #1;
        check(tag, bus_rdata, exp_read(a));
        @(posedge clk);
        #1;
        bus_rd = 1'b0;
        model_apply(1'b1, 1'b0, a, 0);
    endtask

    // interrupt lines compared with the model on every clock (R9)
    always @(negedge clk) begin
        if (running) begin
            logic [31:0] e;
            e = 0;
            for (int u = 0; u < NU; u++) e[u] = |(st[u] & en[u]);
            check("R9 irq lines", {28'h0, irq_out}, e);
        end
    end

    // watchdog: a hung run is a failure
    initial begin
        #(CLK_PERIOD * 50000);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int u = 0; u < NU; u++) begin st[u] = 0; en[u] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        running = 1;

        // R1 reset state
        bus_read('h00, "R1 revision");
        bus_read('h14, "R1 reset done");
        bus_read('h10, "R1 config");
        for (int m = 0; m < NB; m++) bus_read('hC0 + 4*m, "R1 count empty");
        for (int u = 0; u < NU; u++) bus_read('h100 + 8*u, "R1 status");
        for (int u = 0; u < NU; u++) bus_read('h104 + 8*u, "R1 enable");

        // R10 configuration mask
        bus_write('h10, 32'hFFFF_FFFF);
        bus_read('h10, "R10 config mask");
        bus_write('h10, 32'h11);
        bus_read('h10, "R10 config smart idle");

        // R4 / R7 pushes into mailbox 0
        bus_write('h40, 32'hA000_0001);
        bus_write('h40, 32'hA000_0002);
        bus_read('hC0, "R4 count two");
        bus_read('h80, "R4 not full");
        for (int u = 0; u < NU; u++) bus_read('h100 + 8*u, "R7 newmsg all users");

        // R5 overflow
        bus_write('h40, 32'hA000_0003);
        bus_write('h40, 32'hA000_0004);
        bus_read('h80, "R4 full flag");
        bus_write('h40, 32'hDEAD_BEEF);
        bus_read('hC0, "R5 count stays 4");

        // R3 order, R7 not-full event
        for (int i = 0; i < 4; i++) bus_read('h40, "R3 fifo order");
        bus_read('h100, "R7 notfull set");

        // R6 empty pop
        bus_write('h108, 32'hFFF);
        bus_read('h108, "R8 full clear");
        bus_read('h40, "R6 empty returns zero");
        bus_read('h108, "R6 no event on empty pop");
        bus_read('hC0, "R6 count stays zero");

        // R3 independence of mailboxes
        bus_write('h4C, 32'h3333_0000);
        bus_write('h54, 32'h5555_0000);
        bus_write('h4C, 32'h3333_0001);
        bus_read('h54, "R3 box5 word");
        bus_read('h4C, "R3 box3 first");
        bus_read('hCC, "R3 box3 count");
        bus_read('h4C, "R3 box3 second");

        // R8 write-zero keeps, write-one clears selected bits
        bus_write('h110, 32'h0);
        bus_read('h110, "R8 write zero keeps");
        bus_write('h110, 32'h0C0);
        bus_read('h110, "R8 selective clear");

        // R9 enable readback and interrupt gating
        bus_write('h11C, 32'hFFFF_F100);
        bus_read('h11C, "R9 enable readback");
        bus_write('h118, 32'hFFF);
        bus_write('h50, 32'h4444_0000);
        bus_read('h118, "R9 status user3");
        bus_write('h118, 32'h100);
        bus_read('h118, "R9 after ack");
        bus_read('h50, "R3 box4 word");

        // R2 decode edges
        bus_write('h42, 32'h7777_7777);
        bus_write('h58, 32'h8888_8888);
        bus_write('h1F0, 32'h9999_9999);
        bus_read('hC0, "R2 misaligned write ignored");
        bus_read('h58, "R2 above last box");
        bus_read('hD8, "R2 count above last box");
        bus_read('h1F0, "R2 unmapped");
        bus_read('h42, "R2 misaligned read");
        bus_read('h120, "R2 end of space");
        for (int u = 0; u < NU; u++) bus_read('h100 + 8*u, "R2 status unaffected");

        running = 0;
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule